// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a flash array controller. Each accepted host write carries a latched address and a data word, of which only the low byte takes part in command recognition. The decoder steps through the unlock handshake and the code that follows it. Once it has recognised a complete command, it raises a one-cycle request that carries the operation code and the address and data of the final write. The operations are: word program, whole-array erase, sector erase, boot-region lock, and entry to and exit from the identification mode.

The block also holds an identification-mode flag. While that flag is set, the read path takes its byte from the `id_rd_data` output in place of the array. Address bit 0 picks between the maker code and the part code. An external status reporter drives `busy` while an operation runs, and writes made during that time are dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: Every multi-cycle command begins with low byte 0xAA written to address 0x5555 and then low byte 0x55 written to address 0x2AAA. Data bits 15:8 never affect recognition.
- R2: The third write must go to 0x5555, and its low byte chooses the path: 0xA0 word program, 0x80 six-cycle prefix, 0x90 ID entry, 0xF0 ID exit. Any other byte returns the decoder to idle.
- R3: After the 0xA0 path, the fourth write, at any address, issues `req_op`=0 (program). `req_addr` and the full 16-bit `req_data` are taken from that write.
- R4: After the 0x80 path, a second 0xAA@0x5555 / 0x55@0x2AAA pair is required. The sixth write then decides the command: 0x10@0x5555 gives `req_op`=1 (array erase), 0x30 at any address gives `req_op`=2 (sector erase, `req_addr` = that address), and 0x40@0x5555 gives `req_op`=3 (boot lock).
- R5: ID entry issues `req_op`=4, and ID exit issues `req_op`=5. ID exit comes either from the three-cycle path or from a single write of low byte 0xF0 to any address while idle. `id_mode` is set by op 4 and cleared by op 5, taking its new value on the clock edge that ends the request pulse. It changes at no other time except reset.
- R6: `id_rd_data` is 0x1F when `id_mode`=1 and `rd_addr[0]`=0, and 0x92 when `id_mode`=1 and `rd_addr[0]`=1. It is 0x00 while `id_mode`=0.
- R7: A write whose address or low byte does not match the expected step returns the decoder to idle without a request. That write is not taken as the start of a new sequence.
- R8: A write made while `busy`=1 is ignored. It neither advances nor resets the sequence, and it issues no request.
- R9: Each recognised command gives exactly one `req_valid` pulse, one cycle wide, in the cycle after the clock edge that accepts its final write.
- R10: `rst_n`=0 aborts any partial sequence, clears `id_mode` and holds `req_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Latched write address |
| wr_data | input | DW | Write data word |
| busy | input | 1 | Status reporter busy; writes are ignored while high |
| rd_addr | input | AW | Current read address |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | Operation code (0 program, 1 array erase, 2 sector erase, 3 lock, 4 ID entry, 5 ID exit) |
| req_addr | output | AW | Address of the final write of the command |
| req_data | output | DW | Data of the final write of the command |
| id_mode | output | 1 | Identification mode flag |
| id_rd_data | output | 8 | Identification byte for the read path |

## Verification
A wrong internal step shows up at the ports within one write. A correct final write then gives no `req_valid` pulse, or a stray write gives one, or the pulse carries an operation code different from the path that was actually written. A lost or extra identification transition shows as `id_mode` and `id_rd_data` disagreeing with the expected mode on the very next read, two clocks after the write. The bench therefore compares the request fields, the flag and the identification byte after every write, across both directed sequences and randomly corrupted sequences interleaved with busy cycles.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef enum logic [2:0] {
      OP_PROG   = 3'd0,
      OP_CHIP   = 3'd1,
      OP_SECT   = 3'd2,
      OP_LOCK   = 3'd3,
      OP_ID_IN  = 3'd4,
      OP_ID_OUT = 3'd5
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_WORD,
      ST_EUN1,
      ST_EUN2,
      ST_EFIN
   } step_e;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] SEL_PROG   = 8'hA0;
   localparam logic [7:0] SEL_PREFIX = 8'h80;
   localparam logic [7:0] SEL_ID_IN  = 8'h90;
   localparam logic [7:0] SEL_ID_OUT = 8'hF0;
   localparam logic [7:0] FIN_CHIP   = 8'h10;
   localparam logic [7:0] FIN_SECT   = 8'h30;
   localparam logic [7:0] FIN_LOCK   = 8'h40;

endpackage

// File: rtl/fseq_classify.sv
module fseq_classify #(
   parameter int AW = 18,
   parameter int DW = 16,
   parameter logic [AW-1:0] UNL_ADDR1 = AW'('h5555),
   parameter logic [AW-1:0] UNL_ADDR2 = AW'('h2AAA)
) (
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          hit_a1,
   output logic          hit_a2,
   output logic [7:0]    code
);
   // Only the low byte takes part in command decoding.
   assign hit_a1 = (addr == UNL_ADDR1);
   assign hit_a2 = (addr == UNL_ADDR2);
   assign code   = data[7:0];
endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
   import fseq_pkg::*;
#(
   parameter int AW = 18,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          hit_a1,
   input  logic          hit_a2,
   input  logic [7:0]    code,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          req_valid,
   output op_e           req_op,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_data
);
   step_e st, st_nxt;
   logic  fire;
   op_e   fire_op;

   always_comb begin
      st_nxt  = st;
      fire    = 1'b0;
      fire_op = OP_PROG;
      if (accept) begin
         unique case (st)
            ST_IDLE: begin
               if (hit_a1 && code == KEY_FIRST) begin
                  st_nxt = ST_UNL1;
               end else if (code == SEL_ID_OUT) begin
                  fire    = 1'b1;
                  fire_op = OP_ID_OUT;
               end
            end
            ST_UNL1: st_nxt = (hit_a2 && code == KEY_SECOND) ? ST_UNL2 : ST_IDLE;
            ST_UNL2: begin
               st_nxt = ST_IDLE;
               if (hit_a1) begin
                  case (code)
                     SEL_PROG:   st_nxt = ST_WORD;
                     SEL_PREFIX: st_nxt = ST_EUN1;
                     SEL_ID_IN:  begin fire = 1'b1; fire_op = OP_ID_IN;  end
                     SEL_ID_OUT: begin fire = 1'b1; fire_op = OP_ID_OUT; end
                     default: ;
                  endcase
               end
            end
            ST_WORD: begin
               st_nxt  = ST_IDLE;
               fire    = 1'b1;
               fire_op = OP_PROG;
            end
            ST_EUN1: st_nxt = (hit_a1 && code == KEY_FIRST)  ? ST_EUN2 : ST_IDLE;
            ST_EUN2: st_nxt = (hit_a2 && code == KEY_SECOND) ? ST_EFIN : ST_IDLE;
            ST_EFIN: begin
               st_nxt = ST_IDLE;
               if (code == FIN_SECT) begin
                  fire = 1'b1; fire_op = OP_SECT;
               end else if (hit_a1 && code == FIN_CHIP) begin
                  fire = 1'b1; fire_op = OP_CHIP;
               end else if (hit_a1 && code == FIN_LOCK) begin
                  fire = 1'b1; fire_op = OP_LOCK;
               end
            end
            default: st_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         req_valid <= 1'b0;
         req_op    <= OP_PROG;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         st        <= st_nxt;
         req_valid <= fire;
         if (fire) begin
            req_op   <= fire_op;
            req_addr <= addr;
            req_data <= data;
         end
      end
   end
endmodule

// File: rtl/fseq_id_unit.sv
module fseq_id_unit
   import fseq_pkg::*;
#(
   parameter int AW = 18,
   parameter logic [7:0] MFR_CODE = 8'h1F,
   parameter logic [7:0] DEV_CODE = 8'h92,
   parameter bit REG_READ = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  op_e           req_op,
   input  logic [AW-1:0] rd_addr,
   output logic          id_mode,
   output logic [7:0]    id_rd_data
);
   logic [7:0] sel_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_mode <= 1'b0;
      end else if (req_valid) begin
         if (req_op == OP_ID_IN) begin
            id_mode <= 1'b1;
         end else if (req_op == OP_ID_OUT) begin
            id_mode <= 1'b0;
         end
      end
   end

   assign sel_code = !id_mode ? 8'h00 : (rd_addr[0] ? DEV_CODE : MFR_CODE);

   generate
      if (REG_READ) begin : g_reg_read
         logic [7:0] code_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_q <= 8'h00;
            else        code_q <= sel_code;
         end
         assign id_rd_data = code_q;
      end else begin : g_comb_read
         assign id_rd_data = sel_code;
      end
   endgenerate
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fseq_pkg::*;
#(
   parameter int AW = 18,
   parameter int DW = 16,
   parameter logic [AW-1:0] UNL_ADDR1 = AW'('h5555),
   parameter logic [AW-1:0] UNL_ADDR2 = AW'('h2AAA),
   parameter logic [7:0] MFR_CODE = 8'h1F,
   parameter logic [7:0] DEV_CODE = 8'h92,
   parameter bit REG_READ = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          busy,
   input  logic [AW-1:0] rd_addr,
   output logic          req_valid,
   output logic [2:0]    req_op,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_data,
   output logic          id_mode,
   output logic [7:0]    id_rd_data
);
   generate
      if (AW < 15) begin : g_bad_aw
         $error("flash_cmd_seq: AW must be at least 15");
      end
      if (DW < 8) begin : g_bad_dw
         $error("flash_cmd_seq: DW must be at least 8");
      end
   endgenerate

   logic       accept;
   logic       hit_a1, hit_a2;
   logic [7:0] code;
   op_e        op_q;

   assign accept = wr_en && !busy;
   assign req_op = op_q;

   fseq_classify #(
      .AW(AW), .DW(DW), .UNL_ADDR1(UNL_ADDR1), .UNL_ADDR2(UNL_ADDR2)
   ) u_classify (
      .addr(wr_addr), .data(wr_data),
      .hit_a1(hit_a1), .hit_a2(hit_a2), .code(code)
   );

   fseq_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .hit_a1(hit_a1), .hit_a2(hit_a2), .code(code),
      .addr(wr_addr), .data(wr_data),
      .req_valid(req_valid), .req_op(op_q),
      .req_addr(req_addr), .req_data(req_data)
   );

   fseq_id_unit #(
      .AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .REG_READ(REG_READ)
   ) u_id (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_q),
      .rd_addr(rd_addr), .id_mode(id_mode), .id_rd_data(id_rd_data)
   );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
   import fseq_pkg::*;
#(
   parameter int AW = 18,
   parameter int DW = 16,
   parameter logic [AW-1:0] UNL_ADDR1 = AW'('h5555)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          busy,
   input logic          req_valid,
   input logic [2:0]    req_op,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] req_data,
   input logic          id_mode
);
   AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(wr_en && !busy)); // R8

   AST_PROG_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PROG) |-> (req_data == $past(wr_data) && req_addr == $past(wr_addr))); // R3

   AST_CHIP_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_CHIP) |-> ($past(wr_addr) == UNL_ADDR1 && $past(wr_data[7:0]) == 8'h10)); // R4

   AST_ID_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_ID_IN) |=> id_mode); // R5

   AST_ID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_ID_OUT) |=> !id_mode); // R5

   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(id_mode)); // R5
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
   .AW(AW), .DW(DW), .UNL_ADDR1(UNL_ADDR1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .busy(busy), .req_valid(req_valid), .req_op(req_op),
   .req_addr(req_addr), .req_data(req_data), .id_mode(id_mode)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
   localparam int AW = 18;
   localparam int DW = 16;
   localparam logic [AW-1:0] A1 = 18'h05555;
   localparam logic [AW-1:0] A2 = 18'h02AAA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          req_valid;
   logic [2:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          id_mode;
   logic [7:0]    id_rd_data;

   int n_run = 0;
   int n_fail = 0;
   int ms = 0;
   bit mid = 1'b0;

   always #10 clk = ~clk;

   flash_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_data(req_data), .id_mode(id_mode), .id_rd_data(id_rd_data)
   );

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_id(input bit m, input logic [AW-1:0] ra);
      if (!m) return 8'h00;
      return ra[0] ? 8'h92 : 8'h1F;
   endfunction

   function automatic string op_tag(input logic [2:0] op);
      if (op == 3'd0) return "R3";
      if (op <= 3'd3) return "R4";
      return "R5";
   endfunction

   // Reference model of the command sequences, written from the requirements.
   task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b,
                        output bit ev, output logic [2:0] eop);
      logic [7:0] c;
      c = d[7:0];
      ev = 1'b0;
      eop = 3'd0;
      if (b) return;
      case (ms)
         0: if (a == A1 && c == 8'hAA) ms = 1;
            else if (c == 8'hF0) begin ev = 1; eop = 3'd5; end
         1: ms = (a == A2 && c == 8'h55) ? 2 : 0;
         2: begin
               ms = 0;
               if (a == A1) begin
                  if (c == 8'hA0) ms = 3;
                  else if (c == 8'h80) ms = 4;
                  else if (c == 8'h90) begin ev = 1; eop = 3'd4; end
                  else if (c == 8'hF0) begin ev = 1; eop = 3'd5; end
               end
            end
         3: begin ms = 0; ev = 1; eop = 3'd0; end
         4: ms = (a == A1 && c == 8'hAA) ? 5 : 0;
         5: ms = (a == A2 && c == 8'h55) ? 6 : 0;
         default: begin
               ms = 0;
               if (c == 8'h30) begin ev = 1; eop = 3'd2; end
               else if (a == A1 && c == 8'h10) begin ev = 1; eop = 3'd1; end
               else if (a == A1 && c == 8'h40) begin ev = 1; eop = 3'd3; end
            end
      endcase
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b, input string tag);
      bit ev;
      logic [2:0] eop;
      @(negedge clk);
      chk(req_valid == 1'b0, "R9 pulse width", 32'(req_valid), 32'd0);
      chk(id_mode == mid, "R5 id_mode", 32'(id_mode), 32'(mid));
      rd_addr = AW'($urandom);
      #1;
      chk(id_rd_data == exp_id(mid, rd_addr), "R6 id byte", 32'(id_rd_data), 32'(exp_id(mid, rd_addr)));
      wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
      model(a, d, b, ev, eop);
      @(negedge clk);
      chk(req_valid == ev, tag, 32'(req_valid), 32'(ev));
      if (ev && req_valid) begin
         chk(req_op == eop, op_tag(eop), 32'(req_op), 32'(eop));
         chk(req_addr == a, op_tag(eop), 32'(req_addr), 32'(a));
         chk(req_data == d, op_tag(eop), 32'(req_data), 32'(d));
         if (eop == 3'd4) mid = 1'b1;
         if (eop == 3'd5) mid = 1'b0;
      end
      wr_en = 1'b0; busy = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      ms = 0; mid = 1'b0;
      chk(req_valid == 1'b0, "R10 reset req", 32'(req_valid), 32'd0);
      chk(id_mode == 1'b0, "R10 reset id_mode", 32'(id_mode), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic unlock(input string tag);
      do_write(A1, 16'h00AA, 1'b0, tag);
      do_write(A2, 16'h0055, 1'b0, tag);
   endtask

   task automatic run_random(input int kind);
      logic [AW-1:0] sa [6];
      logic [DW-1:0] sd [6];
      int n;
      sa[0] = A1; sd[0] = {8'($urandom), 8'hAA};
      sa[1] = A2; sd[1] = {8'($urandom), 8'h55};
      sa[2] = A1; sd[2] = {8'($urandom), 8'h80};
      sa[3] = A1; sd[3] = {8'($urandom), 8'hAA};
      sa[4] = A2; sd[4] = {8'($urandom), 8'h55};
      sa[5] = A1; sd[5] = 16'h0010;
      n = 6;
      case (kind)
         0: begin sd[2][7:0] = 8'hA0; sa[3] = AW'($urandom); sd[3] = 16'($urandom); n = 4; end
         1: ;
         2: begin sa[5] = AW'($urandom); sd[5][7:0] = 8'h30; end
         3: sd[5][7:0] = 8'h40;
         4: begin sd[2][7:0] = 8'h90; n = 3; end
         5: begin sd[2][7:0] = 8'hF0; n = 3; end
         6: begin sa[0] = AW'($urandom); sd[0][7:0] = 8'hF0; n = 1; end
         default: begin sa[0] = AW'($urandom); sd[0] = 16'($urandom); n = 1; end
      endcase
      for (int i = 0; i < n; i++) begin
         if ($urandom % 8 == 0) sd[i][7:0] = 8'($urandom);
         if ($urandom % 16 == 0) sa[i] = AW'($urandom);
         do_write(sa[i], sd[i], ($urandom % 10) == 0, "R7 random request");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (2) @(negedge clk);
      // R10 reset state at the ports
      chk(req_valid == 1'b0, "R10 reset req", 32'(req_valid), 32'd0);
      chk(id_mode == 1'b0, "R10 reset id_mode", 32'(id_mode), 32'd0);
      chk(id_rd_data == 8'h00, "R6 id byte out of mode", 32'(id_rd_data), 32'd0);
      rst_n = 1'b1;

      // R1 upper data bits ignored, R2/R3 word program
      do_write(A1, 16'h12AA, 1'b0, "R1 unlock");
      do_write(A2, 16'hFF55, 1'b0, "R1 unlock");
      do_write(A1, 16'h00A0, 1'b0, "R2 select");
      do_write(18'h01234, 16'hBEEF, 1'b0, "R3 program");

      // R4 six-cycle commands
      unlock("R4"); do_write(A1, 16'h0080, 1'b0, "R4"); unlock("R4");
      do_write(A1, 16'h0010, 1'b0, "R4 array erase");
      unlock("R4"); do_write(A1, 16'h0080, 1'b0, "R4"); unlock("R4");
      do_write(18'h3F000, 16'h0030, 1'b0, "R4 sector erase");
      unlock("R4"); do_write(A1, 16'h0080, 1'b0, "R4"); unlock("R4");
      do_write(A1, 16'h0040, 1'b0, "R4 lock");
      // R4 wrong sixth address for array erase
      unlock("R4"); do_write(A1, 16'h0080, 1'b0, "R4"); unlock("R4");
      do_write(18'h00100, 16'h0010, 1'b0, "R4 array erase off address");

      // R5 entry, R6 reads, three-cycle exit, shortcut exit
      unlock("R5"); do_write(A1, 16'h0090, 1'b0, "R5 id entry");
      @(negedge clk);
      rd_addr = 18'h00000; #1;
      chk(id_rd_data == 8'h1F, "R6 maker code", 32'(id_rd_data), 32'h1F);
      rd_addr = 18'h00001; #1;
      chk(id_rd_data == 8'h92, "R6 part code", 32'(id_rd_data), 32'h92);
      unlock("R5"); do_write(A1, 16'h00F0, 1'b0, "R5 id exit");
      unlock("R5"); do_write(A1, 16'h0090, 1'b0, "R5 id entry");
      do_write(18'h00777, 16'hABF0, 1'b0, "R5 shortcut exit");

      // R7 mismatch: wrong address on second write, then no request
      do_write(A1, 16'h00AA, 1'b0, "R7");
      do_write(18'h02AAB, 16'h0055, 1'b0, "R7 wrong address");
      do_write(A1, 16'h00A0, 1'b0, "R7 discarded");
      do_write(18'h00040, 16'h5678, 1'b0, "R7 no program");

      // R8 busy write neither advances nor breaks the sequence
      unlock("R8");
      do_write(A1, 16'h00A0, 1'b1, "R8 busy");
      do_write(A1, 16'h00A0, 1'b0, "R8");
      do_write(18'h00200, 16'h0F0F, 1'b1, "R8 busy final");
      do_write(18'h00201, 16'h1111, 1'b0, "R8 program after busy");

      // R10 reset aborts a partial sequence and clears id_mode
      unlock("R10"); do_write(A1, 16'h0090, 1'b0, "R10 id entry");
      unlock("R10");
      do_reset();
      do_write(A1, 16'h00A0, 1'b0, "R10 aborted");
      do_write(18'h00300, 16'h2222, 1'b0, "R10 no program");

      // Random mix
      for (int k = 0; k < 600; k++) run_random(int'($urandom % 8));

      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule